// File: doc/BRIEF.md
# Video Controller CPU Register Front End

This block is the CPU-facing register front end of a tile-based video controller. A host processor reaches it over an 8-bit data bus, using a 3-bit register select, a chip select and separate read and write strobes. It offers three registers. The first is a status register that can be read. The second is a scroll register that takes two bytes, horizontal then vertical. The third is a video memory address register that takes two bytes, high then low. The block drives the assembled scroll bytes and the current 14-bit video memory address to the rest of the controller.

The scroll and address registers share one hidden write-phase bit. Every write to either register uses the current phase to pick which byte it loads, and then inverts the phase. The phase cannot be read back. The only way software can return it to the first-byte position is to read the status register. An address write in the first phase also overwrites the fine vertical scroll bits. For this reason, software must program the scroll after any address update.

Three event inputs from the rendering pipeline set the status flags: vertical blank, sprite-zero hit and sprite overflow. A frame-clear event from the same pipeline clears all three flags.

Top module: `vid_regfront`

## Requirements
- R1: A synchronous active-low reset clears the write phase, all three flags, both scroll bytes, the address staging byte and the address output to zero.
- R2: When a status read is active (`cs`=1, `rd_en`=1, `reg_sel`=2), `rdata` bit 7 is vertical blank, bit 6 is sprite-zero hit and bit 5 is sprite overflow, and bits 4..0 are 0. In every other cycle `rdata` is 0.
- R3: A write with `reg_sel`=5 loads `scroll_x` when the phase is 0 and loads `scroll_y` when the phase is 1. The new value is visible one cycle after the write.
- R4: A write with `reg_sel`=6 in phase 0 stores `wdata[5:0]` as the staged high address bits, ignores `wdata[7:6]` and leaves `vaddr` unchanged. The same write in phase 1 sets `vaddr` to {staged bits, `wdata`}.
- R5: Scroll and address writes share one phase bit. A scroll write followed by an address write makes the address write load the low byte.
- R6: Each accepted scroll or address write inverts the phase, so a third consecutive write acts like the first.
- R7: A status read clears the phase to 0 and clears the vertical-blank flag. It leaves the sprite-zero-hit and sprite-overflow flags unchanged. If a status read and a write happen in the same cycle, the write uses the old phase and the read clear wins.
- R8: When a vertical-blank event arrives in the same cycle as a status read, the read returns bit 7 as 1 and the flag stays set. The same rule applies to the sprite flags and their events.
- R9: An address write in phase 0 replaces `scroll_y[2:0]` with {0, `wdata[5:4]`} and keeps `scroll_y[7:3]`.
- R10: `frame_clr` clears all three flags. If a set event arrives in the same cycle as `frame_clr`, the set event wins for its flag.
- R11: A write with `cs`=0 or with a select other than 5 or 6 changes nothing. A read with any select other than 2 neither returns data nor clears the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| reg_sel | input | 3 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| vblank_evt | input | 1 | Vertical blank start pulse |
| hit_evt | input | 1 | Sprite-zero hit pulse |
| ovf_evt | input | 1 | Sprite overflow pulse |
| frame_clr | input | 1 | Pulse that clears all status flags |
| scroll_x | output | 8 | Horizontal scroll byte |
| scroll_y | output | 8 | Vertical scroll byte, fine bits in [2:0] |
| vaddr | output | 14 | Video memory address |

## Verification
The hardest state to reach is the hidden phase bit, because no port shows it. The bench can only infer the phase from where the next scroll or address byte lands. The stimulus therefore runs interleaved scroll and address writes, including runs of odd length, with status reads at chosen points. After each of these, the bench checks which output moved.

The same-cycle collisions need deliberate stimulus as well: a vertical-blank event during a status read, a set event during `frame_clr`, and a write during a status read. Directed steps place these collisions first. A long random phase then mixes them further against the reference model.

// File: rtl/vid_regfront_pkg.sv
// Package: shared register selects, status bit positions and decoded bus
// operation type for the video register front end.
package vid_regfront_pkg;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_STATUS = 3'd2;
    localparam logic [SEL_W-1:0] SEL_SCROLL = 3'd5;
    localparam logic [SEL_W-1:0] SEL_VADDR  = 3'd6;

    // Flag indices inside the flag vector; status byte places them at [7:5].
    localparam int FLAG_N   = 3;
    localparam int FLAG_OVF = 0;
    localparam int FLAG_HIT = 1;
    localparam int FLAG_VB  = 2;

    typedef struct packed {
        logic stat_rd;
        logic scroll_wr;
        logic addr_wr;
    } bus_op_t;

endpackage

// File: rtl/vid_regfront_decode.sv
// Module: vid_regfront_decode
// Turns chip select, strobes and register select into one decoded bus
// operation per cycle. Assumes strobes are single-cycle per access.
module vid_regfront_decode
    import vid_regfront_pkg::*;
(
    input  logic             cs,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] reg_sel,
    output bus_op_t          op
);

    // Decode the selected register for reads and writes.
    always_comb begin
        op.stat_rd   = cs && rd_en && (reg_sel == SEL_STATUS);
        op.scroll_wr = cs && wr_en && (reg_sel == SEL_SCROLL);
        op.addr_wr   = cs && wr_en && (reg_sel == SEL_VADDR);
    end

endmodule

// File: rtl/vid_regfront_phase.sv
// Module: vid_regfront_phase
// Holds the single write-phase bit shared by the scroll and address
// registers. Any two-byte write inverts it, and a status read forces it to 0.
// Assumes the read clear wins over a same-cycle write.
module vid_regfront_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic pair_wr,
    output logic phase
);

    // Track the shared first/second byte phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= 1'b0;
        else if (stat_rd)
            phase <= 1'b0;
        else if (pair_wr)
            phase <= ~phase;
    end

    assert_phase_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !phase);

    assert_phase_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_wr && !stat_rd) |=> (phase != $past(phase)));

    assert_phase_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_wr && !stat_rd) |=> $stable(phase));

endmodule

// File: rtl/vid_regfront_flags.sv
// Module: vid_regfront_flags
// Status flags set by rendering events. Only the vertical-blank flag is
// cleared by a status read. Frame clear drops all flags. A set event wins
// over any clear in the same cycle and is visible in that cycle's read data.
module vid_regfront_flags
    import vid_regfront_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic              frame_clr,
    input  logic [FLAG_N-1:0] set_evt,
    output logic [DATA_W-1:0] status
);

    localparam int LOW_W = DATA_W - FLAG_N;

    logic [FLAG_N-1:0] flag_q;
    logic [FLAG_N-1:0] flag_view;

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        localparam bit READ_CLR = (i == FLAG_VB);
        // One sticky flag: set wins, then read clear (if enabled), then frame clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (set_evt[i])
                flag_q[i] <= 1'b1;
            else if (frame_clr || (READ_CLR && stat_rd))
                flag_q[i] <= 1'b0;
        end
    end

    // Present flags including same-cycle set events.
    always_comb flag_view = flag_q | set_evt;

    // Drive the status byte only during a status read.
    always_comb begin
        status = '0;
        if (stat_rd)
            status = {flag_view, {LOW_W{1'b0}}};
    end

    assert_vb_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !set_evt[FLAG_VB]) |=> !flag_q[FLAG_VB]);

    assert_hit_survives_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[FLAG_HIT] && !frame_clr) |=> flag_q[FLAG_HIT]);

    assert_ovf_survives_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[FLAG_OVF] && !frame_clr) |=> flag_q[FLAG_OVF]);

    assert_vb_race_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[FLAG_VB] |=> flag_q[FLAG_VB]);

    assert_frame_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_clr && set_evt == '0) |=> (flag_q == '0));

endmodule

// File: rtl/vid_regfront_regs.sv
// Module: vid_regfront_regs
// Scroll bytes, address staging byte and the committed video address.
// The phase input picks the target byte. A phase-0 address write also
// overwrites the fine vertical scroll bits. Assumes one write per cycle.
module vid_regfront_regs #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 14,
    parameter int FINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic              scroll_wr,
    input  logic              addr_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] scroll_x,
    output logic [DATA_W-1:0] scroll_y,
    output logic [ADDR_W-1:0] vaddr
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic [HI_W-1:0] stage_q;

    // Horizontal scroll byte: first-phase scroll write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scroll_x <= '0;
        else if (scroll_wr && !phase)
            scroll_x <= wdata;
    end

    // Vertical scroll byte: second-phase scroll write, or fine bits from an address high write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scroll_y <= '0;
        else if (scroll_wr && phase)
            scroll_y <= wdata;
        else if (addr_wr && !phase)
            scroll_y[FINE_W-1:0] <= {1'b0, wdata[HI_W-1 -: FINE_W-1]};
    end

    // Staging byte for the upper address bits; the top data bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (addr_wr && !phase)
            stage_q <= wdata[HI_W-1:0];
    end

    // Committed address updates only on the second address write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vaddr <= '0;
        else if (addr_wr && phase)
            vaddr <= {stage_q, wdata};
    end

    assert_scroll_x_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scroll_wr && !phase) |=> (scroll_x == $past(wdata)));

    assert_scroll_y_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scroll_wr && phase) |=> (scroll_y == $past(wdata)));

    assert_vaddr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_wr && phase) |=> $stable(vaddr));

    assert_fine_y_clobber_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && !phase) |=>
            (scroll_y[FINE_W-1:0] == {1'b0, $past(wdata[HI_W-1 -: FINE_W-1])}) &&
            (scroll_y[DATA_W-1:FINE_W] == $past(scroll_y[DATA_W-1:FINE_W])));

endmodule

// File: rtl/vid_regfront.sv
// Module: vid_regfront
// CPU register front end of a tile video controller: status read,
// two-byte scroll and two-byte address registers behind one shared phase.
// Assumes a synchronous bus with single-cycle strobes.
module vid_regfront
    import vid_regfront_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 14,
    parameter int FINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              vblank_evt,
    input  logic              hit_evt,
    input  logic              ovf_evt,
    input  logic              frame_clr,
    output logic [DATA_W-1:0] scroll_x,
    output logic [DATA_W-1:0] scroll_y,
    output logic [ADDR_W-1:0] vaddr
);

    bus_op_t           op;
    logic              phase;
    logic              pair_wr;
    logic [FLAG_N-1:0] set_evt;

    // Collect writes that advance the shared phase.
    always_comb pair_wr = op.scroll_wr || op.addr_wr;

    // Pack event pulses into flag order.
    always_comb begin
        set_evt           = '0;
        set_evt[FLAG_VB]  = vblank_evt;
        set_evt[FLAG_HIT] = hit_evt;
        set_evt[FLAG_OVF] = ovf_evt;
    end

    vid_regfront_decode u_decode (
        .cs      (cs),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .op      (op)
    );

    vid_regfront_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_rd (op.stat_rd),
        .pair_wr (pair_wr),
        .phase   (phase)
    );

    vid_regfront_flags #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_rd   (op.stat_rd),
        .frame_clr (frame_clr),
        .set_evt   (set_evt),
        .status    (rdata)
    );

    vid_regfront_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FINE_W(FINE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .scroll_wr (op.scroll_wr),
        .addr_wr   (op.addr_wr),
        .wdata     (wdata),
        .scroll_x  (scroll_x),
        .scroll_y  (scroll_y),
        .vaddr     (vaddr)
    );

    assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd_en && reg_sel == SEL_STATUS) |-> (rdata == '0));

    assert_no_stray_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && wr_en) |=> ($stable(scroll_x) && $stable(scroll_y) && $stable(vaddr)));

endmodule

// File: tb/vid_regfront_tb_top.sv
// Bench: behavioural reference model compared on every clock.
module vid_regfront_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs, rd_en, wr_en;
    logic [2:0]  reg_sel;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        vblank_evt, hit_evt, ovf_evt, frame_clr;
    logic [7:0]  scroll_x, scroll_y;
    logic [13:0] vaddr;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    string cur_req = "R1";

    // Reference state.
    int m_ph, m_vb, m_hit, m_ovf, m_sx, m_sy, m_stage, m_addr;

    always #5 clk = ~clk;

    vid_regfront dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd_en(rd_en), .wr_en(wr_en),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
        .vblank_evt(vblank_evt), .hit_evt(hit_evt), .ovf_evt(ovf_evt),
        .frame_clr(frame_clr), .scroll_x(scroll_x), .scroll_y(scroll_y),
        .vaddr(vaddr)
    );

    task automatic chk(string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic model_reset();
        m_ph = 0; m_vb = 0; m_hit = 0; m_ovf = 0;
        m_sx = 0; m_sy = 0; m_stage = 0; m_addr = 0;
    endtask

    task automatic check_regs();
        chk("scroll_x", int'(scroll_x), m_sx);
        chk("scroll_y", int'(scroll_y), m_sy);
        chk("vaddr",    int'(vaddr),    m_addr);
    endtask

    // One bus cycle: drive, check read data, then advance model and check state.
    task automatic cyc(bit c, bit r, bit w, int sel, int d,
                       bit vb = 0, bit hs = 0, bit os = 0, bit fc = 0);
        bit st, sw, aw;
        int exp_rd;
        @(negedge clk);
        cs = c; rd_en = r; wr_en = w; reg_sel = 3'(sel); wdata = 8'(d);
        vblank_evt = vb; hit_evt = hs; ovf_evt = os; frame_clr = fc;
        st = c && r && sel == 2;
        sw = c && w && sel == 5;
        aw = c && w && sel == 6;
        exp_rd = st ? (((m_vb | vb) << 7) | ((m_hit | hs) << 6) | ((m_ovf | os) << 5)) : 0;
        #1;
        chk("rdata", int'(rdata), exp_rd);
        @(posedge clk);
        if (sw) begin
            if (m_ph == 0) m_sx = d; else m_sy = d;
        end
        if (aw) begin
            if (m_ph == 0) begin
                m_stage = d % 64;
                m_sy = (m_sy / 8) * 8 + ((d / 16) % 4);
            end else begin
                m_addr = m_stage * 256 + d;
            end
        end
        if (st) m_ph = 0;
        else if (sw || aw) m_ph = 1 - m_ph;
        if (vb) m_vb = 1; else if (st || fc) m_vb = 0;
        if (hs) m_hit = 1; else if (fc) m_hit = 0;
        if (os) m_ovf = 1; else if (fc) m_ovf = 0;
        #1;
        check_regs();
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cs = 0; rd_en = 0; wr_en = 0; reg_sel = 0; wdata = 0;
        vblank_evt = 0; hit_evt = 0; ovf_evt = 0; frame_clr = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R1";
        check_regs();
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1"; cyc(1, 1, 0, 2, 0);           // status after reset reads 0

        cur_req = "R3"; cyc(1, 0, 1, 5, 'h12); cyc(1, 0, 1, 5, 'h34);
        cur_req = "R6"; cyc(1, 0, 1, 5, 'h56);        // third write lands in X
        cur_req = "R7"; cyc(1, 1, 0, 2, 0); cyc(1, 0, 1, 5, 'h78);
        cur_req = "R7"; cyc(1, 1, 0, 2, 0);
        cur_req = "R4"; cyc(1, 0, 1, 6, 'hFF);        // top bits ignored, vaddr holds
        cur_req = "R9"; idle();                       // fine Y of scroll_y now 011
        cur_req = "R4"; cyc(1, 0, 1, 6, 'hAB);
        cur_req = "R5"; cyc(1, 1, 0, 2, 0); cyc(1, 0, 1, 5, 'h11); cyc(1, 0, 1, 6, 'h22);
        cur_req = "R9"; cyc(1, 1, 0, 2, 0); cyc(1, 0, 1, 5, 'h00); cyc(1, 0, 1, 5, 'hFF);
        cyc(1, 0, 1, 6, 'h1F); cyc(1, 0, 1, 6, 'h40);
        cur_req = "R8"; cyc(1, 1, 0, 2, 0, 1); cyc(1, 1, 0, 2, 0); cyc(1, 1, 0, 2, 0);
        cur_req = "R7"; cyc(0, 0, 0, 0, 0, 0, 1, 1); cyc(1, 1, 0, 2, 0); cyc(1, 1, 0, 2, 0);
        cur_req = "R10"; cyc(0, 0, 0, 0, 0, 1, 0, 0, 1); cyc(1, 1, 0, 2, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1); cyc(1, 1, 0, 2, 0);
        cur_req = "R2"; cyc(1, 0, 0, 2, 0, 1, 1, 1); cyc(0, 1, 0, 2, 0); cyc(1, 1, 0, 2, 0);
        cur_req = "R11"; cyc(0, 0, 1, 5, 'h99); cyc(1, 0, 1, 3, 'h99); cyc(1, 0, 1, 7, 'h99);
        cyc(1, 0, 1, 5, 'hC3); cyc(1, 1, 0, 5, 0); cyc(1, 1, 0, 6, 0); cyc(1, 0, 1, 5, 'h3C);
        cur_req = "R7"; cyc(1, 0, 1, 6, 'h05); cyc(1, 1, 1, 2, 0); cyc(1, 0, 1, 6, 'h07);

        cur_req = "R5";
        for (int i = 0; i < 4000; i++) begin
            int pick = int'($urandom_range(0, 9));
            int sel  = (pick < 3) ? 5 : (pick < 6) ? 6 : (pick < 8) ? 2 : int'($urandom_range(0, 7));
            cyc($urandom_range(0, 7) != 0, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
                sel, int'($urandom_range(0, 255)),
                $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
                $urandom_range(0, 15) == 0, $urandom_range(0, 20) == 0);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule